// File: doc/BRIEF.md
# FIFO Retransmit Controller

This block sits on the read side of a FIFO and lets a consumer read again data it has already taken out. A request is given by pulling an active-low retransmit input low. On the first read-clock edge that samples it low, the block checks two preconditions. Both enables must have been inactive on the clock before the request. The number of words written since the last master or partial reset must also lie in the legal window. If both hold, the block emits a one-cycle strobe that reloads the read pointer to the first RAM location, so that later reads replay memory from its start.

The upper end of the legal window depends on the timing mode. In standard mode it is two below the memory depth. In first-word-fall-through mode the effective depth is one larger, so the limit is one below the depth. In standard mode the block also forces the empty indication for the setup period. It releases it one read-clock cycle after the reload, or later if no word has been written by then. A request that breaks a precondition does not touch the pointer. It raises a setup-error flag instead, and that flag stays up until a later request is accepted.

Top module: `fifo_retransmit`

## Requirements
- R1: While reset is low and on the first cycle after it is released, `ptrReload`, `forceEmpty` and `setupErr` are all 0.
- R2: When `rtN` is sampled 0 at a rising edge after being sampled 1 at the edge before, and the preconditions hold, `ptrReload` is 1 for exactly the one cycle that follows that edge.
- R3: Holding `rtN` at 0 for further edges starts no further setup; a new setup needs `rtN` to be sampled 1 again first.
- R4: If `renN` or `wenN` was sampled 0 at the edge just before the request edge, the request is rejected: `ptrReload` stays 0 and `setupErr` is 1 from the request edge on.
- R5: A request made while `wrCount` is 0 is rejected in the same way as in R4.
- R6: In standard mode (`fwftMode` = 0), a request with `wrCount` = DEPTH-2 is accepted and one with `wrCount` = DEPTH-1 is rejected.
- R7: In first-word-fall-through mode (`fwftMode` = 1), a request with `wrCount` = DEPTH-1 is accepted and one with `wrCount` = DEPTH is rejected.
- R8: In standard mode, an accepted request sets `forceEmpty` to 1 in the same cycle as `ptrReload`. If `wrCount` is nonzero at the next edge, `forceEmpty` returns to 0 at that edge.
- R9: If `wrCount` is 0 when the release would take place, `forceEmpty` stays 1. It drops at the first edge that samples `wrCount` nonzero.
- R10: In first-word-fall-through mode, an accepted request never sets `forceEmpty`.
- R11: `setupErr` stays 1 after a rejected request until the next accepted request clears it, at the same edge that raises `ptrReload`. A rejected request never sets `forceEmpty`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Read clock |
| rstN | input | 1 | Active-low reset |
| rtN | input | 1 | Active-low retransmit request |
| renN | input | 1 | Active-low read enable |
| wenN | input | 1 | Active-low write enable |
| fwftMode | input | 1 | 1 = first-word-fall-through, 0 = standard |
| wrCount | input | CNT_W | Words written since the last reset |
| ptrReload | output | 1 | One-cycle strobe that reloads the read pointer to location 0 |
| forceEmpty | output | 1 | Empty indication forced during setup |
| setupErr | output | 1 | Last request broke a precondition |

## Verification
Every output is one register away from its inputs. The reload strobe, the forced-empty rise and the error flag all appear in the cycle after the edge that samples `rtN` low. The empty release appears one cycle later, or at the first edge that sees a nonzero count. The driver changes inputs on the falling edge and queues the expected output triple for each cycle that follows a rising edge. The monitor compares that triple just after the next falling edge, so every sample lands halfway between the register update and the following edge.

// File: rtl/rtx_pkg.sv
package rtx_pkg;

  typedef struct packed {
    logic loadPtr;
    logic markEmpty;
    logic releaseEmpty;
    logic flagErr;
  } rtxStrobes_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_HOLD = 1'b1
  } rtxState_t;

endpackage

// File: rtl/rtx_ctrl.sv
module rtx_ctrl
  import rtx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rtN,
  input  logic        renN,
  input  logic        wenN,
  input  logic        fwftMode,
  input  logic        countOk,
  input  logic        cntNonZero,
  output rtxStrobes_t strobes
);

  logic      rtPrev;
  logic      renPrev;
  logic      wenPrev;
  logic      start;
  logic      enablesIdle;
  rtxState_t state;
  rtxState_t stateNext;

  // Sampled copies of the request and both enables from the previous edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rtPrev  <= 1'b1;
      renPrev <= 1'b1;
      wenPrev <= 1'b1;
    end else begin
      rtPrev  <= rtN;
      renPrev <= renN;
      wenPrev <= wenN;
    end
  end

  assign start       = rtPrev & ~rtN;
  assign enablesIdle = renPrev & wenPrev;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          if (enablesIdle && countOk) begin
            strobes.loadPtr   = 1'b1;
            strobes.markEmpty = ~fwftMode;
            if (!fwftMode) stateNext = ST_HOLD;
          end else begin
            strobes.flagErr = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (cntNonZero) begin
          strobes.releaseEmpty = 1'b1;
          stateNext            = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R3: a reload is never issued on two consecutive edges
  p_single_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadPtr |=> !strobes.loadPtr);

  // R11: accept and reject are exclusive within one cycle
  p_accept_xor_reject_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.loadPtr && strobes.flagErr));

endmodule

// File: rtl/rtx_dp.sv
module rtx_dp
  import rtx_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtN,
  input  logic             fwftMode,
  input  logic [CNT_W-1:0] wrCount,
  input  rtxStrobes_t      strobes,
  output logic             countOk,
  output logic             cntNonZero,
  output logic             ptrReload,
  output logic             forceEmpty,
  output logic             setupErr
);

  // Largest legal count: D-2, where D is DEPTH or DEPTH+1
  localparam logic [CNT_W-1:0] STD_MAX  = CNT_W'(DEPTH - 2);
  localparam logic [CNT_W-1:0] FWFT_MAX = CNT_W'(DEPTH - 1);

  logic [CNT_W-1:0] countMax;

  assign countMax   = fwftMode ? FWFT_MAX : STD_MAX;
  assign cntNonZero = (wrCount != '0);
  assign countOk    = cntNonZero && (wrCount <= countMax);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptrReload  <= 1'b0;
      forceEmpty <= 1'b0;
      setupErr   <= 1'b0;
    end else begin
      ptrReload <= strobes.loadPtr;
      if (strobes.markEmpty)         forceEmpty <= 1'b1;
      else if (strobes.releaseEmpty) forceEmpty <= 1'b0;
      if (strobes.flagErr)           setupErr <= 1'b1;
      else if (strobes.loadPtr)      setupErr <= 1'b0;
    end
  end

  p_reload_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    ptrReload |=> !ptrReload);

  p_reload_after_rt_r2: assert property (@(posedge clk) disable iff (!rstN)
    ptrReload |-> !$past(rtN));

  p_err_no_reload_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(setupErr) |-> !ptrReload);

  p_empty_with_reload_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(forceEmpty) |-> ptrReload);

  p_release_r8: assert property (@(posedge clk) disable iff (!rstN)
    (forceEmpty && !ptrReload && wrCount != '0) |=> !forceEmpty);

  p_hold_empty_r9: assert property (@(posedge clk) disable iff (!rstN)
    (forceEmpty && wrCount == '0) |=> forceEmpty);

  p_fwft_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReload && $past(fwftMode)) |-> !forceEmpty);

endmodule

// File: rtl/fifo_retransmit.sv
module fifo_retransmit
  import rtx_pkg::*;
#(
  parameter int DEPTH = 16384,
  parameter int CNT_W = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rtN,
  input  logic             renN,
  input  logic             wenN,
  input  logic             fwftMode,
  input  logic [CNT_W-1:0] wrCount,
  output logic             ptrReload,
  output logic             forceEmpty,
  output logic             setupErr
);

  rtxStrobes_t strobes;
  logic        countOk;
  logic        cntNonZero;

  rtx_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .rtN        (rtN),
    .renN       (renN),
    .wenN       (wenN),
    .fwftMode   (fwftMode),
    .countOk    (countOk),
    .cntNonZero (cntNonZero),
    .strobes    (strobes)
  );

  rtx_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .rtN        (rtN),
    .fwftMode   (fwftMode),
    .wrCount    (wrCount),
    .strobes    (strobes),
    .countOk    (countOk),
    .cntNonZero (cntNonZero),
    .ptrReload  (ptrReload),
    .forceEmpty (forceEmpty),
    .setupErr   (setupErr)
  );

endmodule

// File: tb/sim_fifo_retransmit.sv
module sim_fifo_retransmit;

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 2);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             rtN = 1'b1;
  logic             renN = 1'b1;
  logic             wenN = 1'b1;
  logic             fwftMode = 1'b0;
  logic [CNT_W-1:0] wrCount = '0;
  logic             ptrReload;
  logic             forceEmpty;
  logic             setupErr;

  typedef struct {
    logic  reload;
    logic  empty;
    logic  err;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  fails = 0;
  logic expErr = 1'b0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  fifo_retransmit #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .rtN(rtN), .renN(renN), .wenN(wenN),
    .fwftMode(fwftMode), .wrCount(wrCount),
    .ptrReload(ptrReload), .forceEmpty(forceEmpty), .setupErr(setupErr)
  );

  task automatic push(input logic r, input logic e, input logic x, input string tag);
    expItem_t it;
    it.reload = r; it.empty = e; it.err = x; it.tag = tag;
    expQ.push_back(it);
  endtask

  task automatic cmp(input logic act, input logic exp, input string what, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        cmp(ptrReload, it.reload, "ptrReload", it.tag);
        cmp(forceEmpty, it.empty, "forceEmpty", it.tag);
        cmp(setupErr, it.err, "setupErr", it.tag);
      end
    end
  end

  // Driver: one retransmit attempt; holdZero cycles of zero count after accept
  task automatic attempt(input logic renLow, input logic wenLow, input int cnt,
                         input logic fwft, input int holdZero, input string tag);
    logic ok;
    int   lim;
    lim = fwft ? DEPTH - 1 : DEPTH - 2;
    ok  = !renLow && !wenLow && cnt >= 1 && cnt <= lim;
    @(negedge clk);
    rtN = 1'b1; renN = !renLow; wenN = !wenLow;
    wrCount = CNT_W'(cnt); fwftMode = fwft;
    @(negedge clk);
    renN = 1'b1; wenN = 1'b1; rtN = 1'b0;
    @(negedge clk);
    expErr = ok ? 1'b0 : 1'b1;
    push(ok, ok && !fwft, expErr, tag);
    if (ok && !fwft && holdZero > 0) begin
      wrCount = '0;
      for (int i = 0; i < holdZero; i++) begin
        @(negedge clk);
        push(1'b0, 1'b1, expErr, "R9");
      end
      wrCount = CNT_W'(cnt);
    end
    @(negedge clk);
    push(1'b0, 1'b0, expErr, (holdZero > 0) ? "R9" : "R8");
    @(negedge clk);
    push(1'b0, 1'b0, expErr, "R3");
    rtN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    push(1'b0, 1'b0, 1'b0, "R1");
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    push(1'b0, 1'b0, 1'b0, "R1");

    attempt(1'b0, 1'b0, 5, 1'b0, 0, "R2");
    attempt(1'b1, 1'b0, 5, 1'b0, 0, "R4");
    attempt(1'b0, 1'b0, 5, 1'b0, 0, "R11");
    attempt(1'b0, 1'b1, 5, 1'b0, 0, "R4");
    attempt(1'b0, 1'b0, 0, 1'b0, 0, "R5");
    attempt(1'b0, 1'b0, DEPTH - 2, 1'b0, 0, "R6");
    attempt(1'b0, 1'b0, DEPTH - 1, 1'b0, 0, "R6");
    attempt(1'b0, 1'b0, DEPTH - 1, 1'b1, 0, "R7");
    attempt(1'b0, 1'b0, DEPTH, 1'b1, 0, "R7");
    attempt(1'b0, 1'b0, 3, 1'b1, 0, "R10");
    attempt(1'b0, 1'b0, 7, 1'b0, 3, "R9");
    attempt(1'b0, 1'b0, 1, 1'b0, 0, "R8");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule